// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an asynchronous 8192-word by 8-bit static RAM. It turns each single-word host request into a sequence of RAM control levels whose phase lengths meet the RAM's minimum timings. The RAM has two selects of opposite polarity: a select that is active low and an enable that is active high. It also has an active-low output enable and an active-low write enable. The data bus is split into an outbound word, an inbound word and a drive-enable, so the pad-level tristate can live outside the block.

Every timing minimum is a parameter in nanoseconds, and the clock period is a parameter too. Each one is turned into a clock count by rounding up, and every phase lasts at least one cycle. The state machine has five states. ST_IDLE keeps the RAM in standby and accepts a request. ST_RD_ACC holds the read access window and captures the data on its last edge. ST_RD_REL lets the RAM release the bus. ST_WR_PULSE holds the write overlap while the controller drives the data. ST_WR_TAIL pads the write out to the full cycle time. The transitions are as follows. ST_IDLE goes to ST_RD_ACC on a read request and to ST_WR_PULSE on a write request. ST_RD_ACC goes to ST_RD_REL, and ST_WR_PULSE goes to ST_WR_TAIL, when the phase timer expires. ST_RD_REL and ST_WR_TAIL both return to ST_IDLE when the timer expires.

Top module: `sram_ctl`

## Requirements
- R1: After reset, and whenever the controller is idle, the RAM is in standby: mem_cs_n=1, mem_ce=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0, ready=1 and rd_valid=0.
- R2: A read holds mem_cs_n=0, mem_ce=1, mem_we_n=1 and mem_oe_n=0 for RD_CYC cycles. RD_CYC is the largest of the rounded-up read cycle time, address access time and output-enable access time (9 at the defaults). mem_dq_in is captured on the clock edge that ends this window.
- R3: rd_valid is high for exactly one cycle, the cycle after the capture edge (the 10th cycle after acceptance at the defaults), and rd_data then carries the captured word.
- R4: A write holds mem_cs_n=0, mem_ce=1 and mem_we_n=0 for WR_CYC cycles. WR_CYC is the larger of the rounded-up write pulse width and data setup time (5 at the defaults). mem_oe_n stays 1 throughout, and mem_dq_oe is 1 exactly while mem_we_n is 0.
- R5: mem_addr and mem_dq_out do not change while mem_we_n is low. mem_addr changes only at acceptance.
- R6: ready falls on the edge that accepts a request. A write keeps it low for WR_CYC + WT_CYC cycles, where WT_CYC = max(1, ceil(write cycle) - WR_CYC) (7 in total at the defaults).
- R7: A read keeps ready low for RD_CYC + REL_CYC cycles (12 at the defaults). After the read window ends, the controller does not raise mem_dq_oe within REL_CYC = ceil(bus release time) cycles (3 at the defaults).
- R8: A request raised while ready is low is ignored. It produces no write window, does not change the stored word at its address, and does not stretch the busy time.
- R9: Each nanosecond parameter is converted to cycles as ceil(t / CLK_NS), and each phase takes at least one cycle.
- R10: A word written at an address is returned by a later read of that address. All 13 address bits reach the RAM, so distinct addresses hold distinct words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, sampled while ready is high |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address of the request |
| req_wdata | input | 8 | Word to write |
| ready | output | 1 | High when a request can be accepted |
| rd_data | output | 8 | Captured read word |
| rd_valid | output | 1 | One-cycle pulse marking rd_data as new |
| mem_addr | output | 13 | RAM address |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_ce | output | 1 | RAM enable, active high |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive-enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from the RAM |

## Verification
The bench's RAM model drives the complement of the stored word until the access time has fully elapsed, so a capture that comes even one cycle early reads back wrong. Walking-one addresses, together with all-zero and all-one addresses, separate each address bit from its neighbours. A coprime-stride sweep that writes and then immediately reads back tests the read-after-write turnaround. Blocks of back-to-back writes followed by back-to-back reads test write-after-write and read-after-read. Stray requests raised mid-operation show whether the busy guard is respected, and a later read of the stray target confirms it.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_REL,
        ST_WR_PULSE,
        ST_WR_TAIL
    } ctl_state_t;

    // Round a nanosecond minimum up to whole clock periods.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        if (t_ns <= 0) return 0;
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_ctl_capture.sv
module sram_ctl_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              valid
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= cap;
            if (cap) dout <= din;
        end
    end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 8,
    parameter int T_RC_NS  = 70,
    parameter int T_ACC_NS = 70,
    parameter int T_OE_NS  = 30,
    parameter int T_WC_NS  = 55,
    parameter int T_WP_NS  = 40,
    parameter int T_DW_NS  = 25,
    parameter int T_REL_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // Phase lengths in cycles, each at least one (R9)
    localparam int RD_CYC  = max_int(1, max_int(ns_to_cyc(T_RC_NS, CLK_NS),
                                     max_int(ns_to_cyc(T_ACC_NS, CLK_NS),
                                             ns_to_cyc(T_OE_NS, CLK_NS))));
    localparam int WR_CYC  = max_int(1, max_int(ns_to_cyc(T_WP_NS, CLK_NS),
                                                ns_to_cyc(T_DW_NS, CLK_NS)));
    localparam int WT_CYC  = max_int(1, ns_to_cyc(T_WC_NS, CLK_NS) - WR_CYC);
    localparam int REL_CYC = max_int(1, ns_to_cyc(T_REL_NS, CLK_NS));
    localparam int MAX_CYC = max_int(max_int(RD_CYC, WR_CYC), max_int(WT_CYC, REL_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    ctl_state_t        state, state_nx;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              accept;
    logic              capture;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign accept  = (state == ST_IDLE) && req;
    assign capture = (state == ST_RD_ACC) && tmr_done;

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_ctl_capture #(.DATA_W(DATA_W)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (capture),
        .din   (mem_dq_in),
        .dout  (rd_data),
        .valid (rd_valid)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Address and write word are latched only at acceptance (R5)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Next state and phase timer loading
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    tmr_load = 1'b1;
                    if (req_wr) begin
                        state_nx = ST_WR_PULSE;
                        tmr_val  = CNT_W'(WR_CYC - 1);
                    end else begin
                        state_nx = ST_RD_ACC;
                        tmr_val  = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_done) begin
                    state_nx = ST_RD_REL;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(REL_CYC - 1);
                end
            end
            ST_RD_REL: begin
                if (tmr_done) state_nx = ST_IDLE;
            end
            ST_WR_PULSE: begin
                if (tmr_done) begin
                    state_nx = ST_WR_TAIL;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(WT_CYC - 1);
                end
            end
            ST_WR_TAIL: begin
                if (tmr_done) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        ready     = 1'b0;
        mem_cs_n  = 1'b1;
        mem_ce    = 1'b0;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state)
            ST_IDLE: ready = 1'b1;
            ST_RD_ACC: begin
                mem_cs_n = 1'b0;
                mem_ce   = 1'b1;
                mem_oe_n = 1'b0;
            end
            ST_WR_PULSE: begin
                mem_cs_n  = 1'b0;
                mem_ce    = 1'b1;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_RD_REL, ST_WR_TAIL: ;
            default: ;
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_ce,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_cs_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R3

    AST_WRITE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_cs_n && mem_ce && mem_dq_oe)); // R4

    AST_DRIVE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n); // R4

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr)); // R5

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_dq_out)); // R5

    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req) |=> !ready); // R6
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .ready      (ready),
    .rd_valid   (rd_valid),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_ce     (mem_ce),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;
    function automatic int cdiv(input int t, input int p);
        return (t <= 0) ? 0 : (t + p - 1) / p;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected phase lengths from the requirements (R9), 8 ns clock
    localparam int E_RD  = mx(1, mx(cdiv(70, 8), mx(cdiv(70, 8), cdiv(30, 8))));
    localparam int E_WP  = mx(1, mx(cdiv(40, 8), cdiv(25, 8)));
    localparam int E_WT  = mx(1, cdiv(55, 8) - E_WP);
    localparam int E_REL = mx(1, cdiv(20, 8));

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, rd_valid;
    logic [7:0]  rd_data;
    logic [12:0] mem_addr;
    logic        mem_cs_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'h5A;

    always #4 clk = ~clk;

    sram_ctl u_sram_ctl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int failures = 0;
    bit done_flag = 1'b0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // RAM model contents (written from pin activity) and host-side shadow
    logic [7:0] ram [int];
    logic [7:0] shadow [int];
    function automatic logic [7:0] ram_rd(input int a);
        return ram.exists(a) ? ram[a] : 8'h00;
    endfunction
    function automatic logic [7:0] shadow_rd(input int a);
        return shadow.exists(a) ? shadow[a] : 8'h00;
    endfunction

    int          wcnt = 0;
    int          rcnt = 0;
    int          quiet = 1000;
    int          nwin = 0;
    int          nwrites = 0;
    logic [12:0] waddr;
    logic [7:0]  wdat;
    bit          stable_ok, drv_ok;

    // Pin-level RAM model and write-window monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n && mem_ce && !mem_we_n) begin
                if (wcnt == 0) begin
                    waddr = mem_addr; wdat = mem_dq_out;
                    stable_ok = 1'b1; drv_ok = 1'b1;
                    chk(quiet >= E_REL, "R7 bus release before drive", quiet, E_REL);
                end else if (mem_addr != waddr || mem_dq_out != wdat) begin
                    stable_ok = 1'b0;
                end
                if (!mem_dq_oe || !mem_oe_n) drv_ok = 1'b0;
                wcnt++;
            end else if (wcnt != 0) begin
                ram[int'(waddr)] = wdat;
                nwin++;
                chk(wcnt == E_WP, "R4 write window length", wcnt, E_WP);
                chk(drv_ok, "R4 drive/oe in window", drv_ok, 1);
                chk(stable_ok, "R5 addr/data stable in window", stable_ok, 1);
                wcnt = 0;
            end
            if (!mem_cs_n && mem_ce && mem_we_n && !mem_oe_n) begin
                rcnt++; quiet = 0;
            end else begin
                rcnt = 0;
                if (quiet < 1000) quiet++;
            end
            if (rcnt == 0)          mem_dq_in = 8'h5A;
            else if (rcnt >= E_RD)  mem_dq_in = ram_rd(int'(mem_addr));
            else                    mem_dq_in = ~ram_rd(int'(mem_addr));
        end
    end

    // One host operation; optional stray request while busy
    task automatic op(input bit wr, input logic [12:0] a, input logic [7:0] d,
                      input bit stray, input logic [12:0] sa,
                      output int busy, output int vcnt, output int vidx,
                      output logic [7:0] vdata);
        int k;
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        if (wr) begin shadow[int'(a)] = d; nwrites++; end
        @(negedge clk);
        req = 1'b0;
        vcnt = 0; vidx = 0; vdata = 8'h00; k = 1;
        while (k < 100) begin
            if (rd_valid) begin vcnt++; vidx = k; vdata = rd_data; end
            if (ready) break;
            if (stray && k == 3) begin
                req = 1'b1; req_wr = 1'b1; req_addr = sa; req_wdata = 8'h99;
            end else begin
                req = 1'b0;
            end
            k++;
            @(negedge clk);
        end
        req = 1'b0;
        busy = k - 1;
    endtask

    task automatic do_write(input logic [12:0] a, input logic [7:0] d, input bit stray,
                            input logic [12:0] sa);
        int b, vc, vi; logic [7:0] vd;
        op(1'b1, a, d, stray, sa, b, vc, vi, vd);
        chk(b == E_WP + E_WT, "R6 write busy length", b, E_WP + E_WT);
        chk(vc == 0, "R3 no valid on write", vc, 0);
    endtask

    task automatic do_read(input logic [12:0] a, input bit stray, input logic [12:0] sa);
        int b, vc, vi; logic [7:0] vd;
        op(1'b0, a, 8'h00, stray, sa, b, vc, vi, vd);
        chk(b == E_RD + E_REL, "R7 read busy length", b, E_RD + E_REL);
        chk(vc == 1, "R3 valid pulse count", vc, 1);
        chk(vi == E_RD + 1, "R2 capture timing", vi, E_RD + 1);
        chk(vd == shadow_rd(int'(a)), "R10 read data", vd, shadow_rd(int'(a)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [12:0] a;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(mem_cs_n === 1'b1 && mem_ce === 1'b0, "R1 selects in reset", {mem_cs_n, mem_ce}, 2'b10);
        chk(mem_we_n === 1'b1 && mem_oe_n === 1'b1, "R1 enables in reset", {mem_we_n, mem_oe_n}, 2'b11);
        chk(mem_dq_oe === 1'b0 && rd_valid === 1'b0, "R1 drive/valid in reset", {mem_dq_oe, rd_valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ready === 1'b1 && mem_cs_n && !mem_ce, "R1 idle standby", {ready, mem_cs_n, mem_ce}, 3'b110);

        // R10: walking-one, all-zero and all-one addresses
        for (int i = 0; i < 13; i++) do_write(13'(1 << i), 8'(i * 17 + 3), 1'b0, '0);
        do_write(13'h0000, 8'hC3, 1'b0, '0);
        do_write(13'h1FFF, 8'h3C, 1'b0, '0);
        for (int i = 0; i < 13; i++) do_read(13'(1 << i), 1'b0, '0);
        do_read(13'h0000, 1'b0, '0);
        do_read(13'h1FFF, 1'b0, '0);
        @(negedge clk);
        chk(ready && mem_cs_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe,
            "R1 standby between requests", ready, 1);

        // R2 R10: coprime stride, write then immediate read
        for (int i = 0; i < 200; i++) begin
            a = 13'((i * 41 + 7) % 8192);
            do_write(a, 8'((i * 29 + int'(a[12:5])) % 256), 1'b0, '0);
            do_read(a, 1'b0, '0);
        end

        // Back-to-back writes then back-to-back reads
        for (int i = 0; i < 40; i++) do_write(13'((i * 203 + 11) % 8192), 8'(255 - i * 5), 1'b0, '0);
        for (int i = 0; i < 40; i++) do_read(13'((i * 203 + 11) % 8192), 1'b0, '0);

        // R8: stray requests while busy are ignored
        do_write(13'h0AAA, 8'h11, 1'b0, '0);
        do_read(13'h0555, 1'b1, 13'h0AAA);
        do_write(13'h0556, 8'h22, 1'b1, 13'h0AAA);
        do_read(13'h0AAA, 1'b0, '0);
        repeat (2) @(negedge clk);
        chk(nwin == nwrites, "R8 write windows equal host writes", nwin, nwrites);

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule